// File: doc/BRIEF.md
# Sliding-Window Seed Pool Controller

This block connects a slow entropy source to an external hash engine. Once per refresh interval it samples a fresh group of random bits and shifts that group into a 72-bit pool. Between refreshes it can serve several consumer requests. For each request it presents a different 64-bit slice of the pool to the hash engine as a seed. It then returns the engine's 512-bit digest to the consumer.

The slice position is an offset. The offset starts at zero after every refresh and advances by one for each request that is accepted. In one interval the pool can therefore produce one seed per distinct slice position, and no more. A request that cannot be served yet is held, and the busy output stays high until the request can start.

The hash core is not part of this block. It appears only as a seed handshake and a digest return strobe.

Top module: `seed_pool_ctrl`

## Requirements
- R1: Every TICK_CYCLES clock cycles, counting from the end of reset, one refresh occurs. The refresh takes the first occurs at the TICK_CYCLES-th rising edge after reset is released. At a refresh the pool shifts right by GROUP_W bits, and the value on `ent_bits` enters at the top bits [71:63].
- R2: No request is started until GROUPS refreshes have happened since reset. With the defaults a request pending from reset starts at the edge after the eighth refresh. By then the first sampled group sits in bits [8:0] and the newest group sits in [71:63].
- R3: A started request latches pool bits [ofs+63:ofs] onto `seed_data`, where ofs is the slice offset. The first request after any refresh uses ofs 0.
- R4: Each started request advances the offset by one. At most 9 requests start per interval. A tenth request waits, with `rq_busy` high, until after the next refresh.
- R5: A refresh returns the offset to 0.
- R6: If a refresh and a request start would fall on the same edge, the refresh wins. The request then starts one edge later, using offset 0 on the refreshed pool.
- R7: Once raised, `seed_valid` stays high with `seed_data` unchanged until `seed_ready` is sampled high. After that acceptance `seed_valid` falls.
- R8: After the seed is accepted, the first `dig_valid` captures `dig_data`. On the next cycle `rsp_valid` is high for exactly one cycle, with `rsp_data` equal to the captured digest. A `dig_valid` that arrives while no seed has been accepted is ignored.
- R9: During and just after reset, `seed_valid` and `rsp_valid` are 0 and `rq_busy` is 1.
- R10: `rq_busy` is high unless all of the following hold: the controller is idle, the pool is full, the offset is below 9, and no refresh happens on this edge. A request starts on an edge exactly when `rq_valid` is high and `rq_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_bits | input | GROUP_W | Fresh random group, sampled at each refresh |
| rq_valid | input | 1 | Consumer request, held high until `rsp_valid` |
| rq_busy | output | 1 | A request cannot start on this edge |
| seed_valid | output | 1 | A seed is offered to the hash engine |
| seed_ready | input | 1 | The hash engine accepts the seed |
| seed_data | output | SEED_W | Seed slice taken from the pool |
| dig_valid | input | 1 | Digest strobe from the hash engine |
| dig_data | input | DIGEST_W | Digest from the hash engine |
| rsp_valid | output | 1 | One-cycle response strobe to the consumer |
| rsp_data | output | DIGEST_W | Digest returned to the consumer |

## Verification
Some rules are checked by assertions on every cycle:
- the seed is held stable until it is accepted,
- the offset never exceeds its bound,
- a refresh always clears the offset and blocks a start on the same edge,
- a seed is never raised before the pool is full or while busy,
- the response strobe lasts exactly one cycle,
- the newest group lands in the top bits of the pool.

Other behaviour can only be shown by the bench's scenarios:
- which pool slice each successive request actually receives,
- the exact edge at which a request is released after the first fill, after the ninth request, or against a colliding refresh,
- that a stray digest strobe has no effect.

// File: rtl/seed_pool_ctrl.sv
module seed_pool_ctrl #(
  parameter int GROUP_W     = 9,
  parameter int GROUPS      = 8,
  parameter int SEED_W      = 64,
  parameter int DIGEST_W    = 512,
  parameter int TICK_CYCLES = 2500000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GROUP_W-1:0]  ent_bits,
  input  logic                rq_valid,
  output logic                rq_busy,
  output logic                seed_valid,
  input  logic                seed_ready,
  output logic [SEED_W-1:0]   seed_data,
  input  logic                dig_valid,
  input  logic [DIGEST_W-1:0] dig_data,
  output logic                rsp_valid,
  output logic [DIGEST_W-1:0] rsp_data
);
  localparam int POOL_W  = GROUP_W * GROUPS;
  localparam int WINDOWS = POOL_W - SEED_W + 1;
  localparam int OFS_W   = $clog2(WINDOWS + 1);
  localparam int TICK_W  = $clog2(TICK_CYCLES);
  localparam int FILL_W  = $clog2(GROUPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RESP} state_t;

  state_t              st;
  logic [TICK_W-1:0]   tcnt;
  logic [POOL_W-1:0]   pool;
  logic [FILL_W-1:0]   fill;
  logic [OFS_W-1:0]    ofs;
  logic                tick, full, start;

  assign tick       = (tcnt == TICK_W'(TICK_CYCLES - 1));
  assign full       = (fill == FILL_W'(GROUPS));
  assign rq_busy    = !(st == S_IDLE && full && ofs < OFS_W'(WINDOWS) && !tick);
  assign start      = rq_valid && !rq_busy;
  assign seed_valid = (st == S_SEND);
  assign rsp_valid  = (st == S_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      pool <= '0;
      fill <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + TICK_W'(1);
      if (tick) begin
        pool <= {ent_bits, pool[POOL_W-1:GROUP_W]};
        if (!full) fill <= fill + FILL_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ofs <= '0;
    else if (tick)  ofs <= '0;
    else if (start) ofs <= ofs + OFS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      seed_data <= '0;
      rsp_data  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          seed_data <= pool[ofs +: SEED_W];
          st        <= S_SEND;
        end
        S_SEND: if (seed_ready) st <= S_WAIT;
        S_WAIT: if (dig_valid) begin
          rsp_data <= dig_data;
          st       <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pool[POOL_W-1 -: GROUP_W] == $past(ent_bits));
  p_fill_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_valid) |-> full);
  p_ofs_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ofs <= OFS_W'(WINDOWS));
  p_tick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ofs == '0);
  p_refresh_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !$rose(seed_valid));
  p_seed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid && !seed_ready |=> seed_valid && $stable(seed_data));
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_busy |=> !$rose(seed_valid));
endmodule

// File: tb/seed_pool_ctrl_tb.sv
module seed_pool_ctrl_tb;
  localparam int T = 200;

  logic clk = 0, rst_n = 0;
  logic [8:0]   ent_bits;
  logic         rq_valid = 0, seed_ready = 0, dig_valid = 0;
  logic         rq_busy, seed_valid, rsp_valid;
  logic [63:0]  seed_data;
  logic [511:0] dig_data = '0, rsp_data;

  int e = 0, vectors = 0, miscompares = 0, cnt = 0, last_n = -1;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) e <= e + 1;

  function automatic logic [8:0] g(input int n);
    return 9'((n * 37 + 5) % 512);
  endfunction
  function automatic logic [71:0] pm(input int n);
    logic [71:0] p = '0;
    for (int k = 0; k < 8; k++) p[9*k +: 9] = g(n - 7 + k);
    return p;
  endfunction
  function automatic logic [511:0] dg(input logic [63:0] s);
    return {8{s}} ^ {16{32'h5a3c_96e1}};
  endfunction

  always @(negedge clk) ent_bits = g(e / T + 1);

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at e=%0d", req, act, exp, e);
    end
  endtask

  task automatic serve(input int dr, input int dd, input int exp_e);
    logic [63:0] xs;
    int n, w;
    rq_valid = 1;
    w = 0;
    @(negedge clk);
    while (!seed_valid && w < 3000) begin @(negedge clk); w++; end
    n = e / T;
    if (n != last_n) begin cnt = 0; last_n = n; end
    if (exp_e >= 0) chk(e == exp_e, "R2/R6 start edge", 512'(e), 512'(exp_e));
    xs = 64'(pm(n) >> cnt);
    chk(seed_data == xs, (cnt == 8) ? "R1/R3 window" : "R3/R4 window", 512'(seed_data), 512'(xs));
    cnt++;
    for (int i = 0; i < dr; i++) begin
      @(negedge clk);
      chk(seed_valid && seed_data == xs, "R7 hold", 512'(seed_data), 512'(xs));
    end
    seed_ready = 1;
    @(negedge clk);
    seed_ready = 0;
    chk(!seed_valid, "R7 drop", 512'(seed_valid), 512'(0));
    for (int i = 0; i < dd; i++) @(negedge clk);
    dig_valid = 1; dig_data = dg(xs);
    @(negedge clk);
    dig_valid = 0;
    chk(rsp_valid && rsp_data == dg(xs), "R8 digest", rsp_data, dg(xs));
    rq_valid = 0;
    @(negedge clk);
    chk(!rsp_valid, "R8 pulse", 512'(rsp_valid), 512'(0));
  endtask

  seed_pool_ctrl #(.TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .ent_bits(ent_bits), .rq_valid(rq_valid), .rq_busy(rq_busy),
    .seed_valid(seed_valid), .seed_ready(seed_ready), .seed_data(seed_data),
    .dig_valid(dig_valid), .dig_data(dig_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  initial begin
    repeat (3) @(negedge clk);
    chk(!seed_valid && !rsp_valid && rq_busy, "R9 reset", {seed_valid, rsp_valid, rq_busy}, 512'b001);
    rst_n = 1;
    // R2: request pending from reset is held until the pool fills
    serve(2, 1, 8*T + 1);
    // R4: nine requests in one interval, then a tenth waits (R5, R10)
    while (e < 9*T + 2) @(negedge clk);
    for (int k = 0; k < 9; k++) serve(k % 3, (k * 2) % 5, -1);
    rq_valid = 1;
    @(negedge clk);
    chk(rq_busy && !seed_valid, "R4/R10 tenth busy", {rq_busy, seed_valid}, 512'b10);
    serve(1, 1, 10*T + 1);
    // R8: stray digest strobe while idle is ignored
    @(negedge clk);
    dig_valid = 1; dig_data = '1;
    @(negedge clk);
    dig_valid = 0;
    chk(!rsp_valid, "R8 stray digest", 512'(rsp_valid), 512'(0));
    @(negedge clk);
    chk(!rsp_valid && rsp_data == dg(64'(pm(10))), "R8 stray digest", rsp_data, dg(64'(pm(10))));
    // R6: request arriving on the refresh edge
    while (e < 12*T - 1) @(negedge clk);
    serve(0, 0, 12*T + 1);
    // sweep: k requests in interval 13+k
    for (int k = 1; k <= 5; k++) begin
      while (e < (13 + k)*T + 2) @(negedge clk);
      for (int j = 0; j < k; j++) serve((j + k) % 4, j % 3, -1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule